// File: doc/BRIEF.md
# Latched Sixteen-Way Analog Switch Controller

This block is the digital control for a sixteen-input, one-output analog switch tree. The first level of the tree is sixteen channel cells, each built as two series switches with a shunt-to-ground switch between them. These cells form two banks of eight. Each bank reaches the common output through one second-level series switch. The block takes a channel address, an enable, a chip select and an inverted chip select. It holds them in latches that follow the inputs while the strobe is high and keep their value while the strobe is low. It then drives every switch gate as a plain logic level.

A sequencer separates the latched request from the gates. It has three states. In `ST_OFF`, nothing is connected. In `ST_ON`, one channel and its bank switch are closed. In `ST_GAP`, the tree is fully open for `BBM_CYCLES` clock cycles during a channel change, so that two inputs never share the output. The transitions are named as follows. `OFF->ON` happens on a qualified request. `ON->OFF` happens when the request stops being qualified. `ON->GAP` happens when a qualified request names a different channel. `GAP->ON` happens when the gap count ends and the request is still qualified. `GAP->OFF` happens when the gap count ends and the request has been withdrawn. A status output reports whether any channel is connected.

Top module: `mux_switch_ctrl`

## Requirements
- R1: Inputs are captured at each rising clock edge at which `strobe` is 1. While `strobe` is 0, the held address and select condition do not change, whatever the inputs do.
- R2: A request is qualified only when `en`=1, `cs`=1 and `cs_n`=0. The qualified condition is held in the latch together with the address.
- R3: With a qualified request, latched address code k (0 to 15) connects channel index k, which is bit k of the channel vectors (code 0 is the first input and code 15 is the sixteenth).
- R4: With an unqualified request, no channel is connected, whatever the address.
- R5: For every cell, `ch_ser_in` equals `ch_ser_out`, and `ch_shunt` is their inverse.
- R6: On every cycle, at most one channel series pair is closed and at most one bank switch is closed.
- R7: Address bit 3 picks the bank. A value of 0 closes `bank_ser[0]` (channels 0 to 7) and a value of 1 closes `bank_ser[1]` (channels 8 to 15). A bank switch is closed only while a channel of its bank is connected.
- R8: `any_on` is 1 exactly when some channel is connected.
- R9: When a connected channel is replaced by a different qualified address, the old channel stays connected until the sequencer sees the new request. All series switches are then open for `BBM_CYCLES` cycles before the new channel closes. The block never goes straight from one closed channel to another.
- R10: Synchronous reset opens every series and bank switch, closes every shunt, clears the held select condition and drives `any_on` to 0. The tree stays open after reset until a new qualified request is strobed.
- R11: Strobing the address that is already connected again causes no gap. The channel stays closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| strobe | input | 1 | Latch follow (1) / hold (0) |
| addr | input | 4 | Channel address |
| en | input | 1 | Enable, active high |
| cs | input | 1 | Chip select, active high |
| cs_n | input | 1 | Chip select, active low |
| ch_ser_in | output | 16 | Input-side series switch gate per channel, 1 = closed |
| ch_ser_out | output | 16 | Output-side series switch gate per channel, 1 = closed |
| ch_shunt | output | 16 | Shunt-to-ground gate per channel, 1 = closed |
| bank_ser | output | 2 | Second-level bank switch gates, 1 = closed |
| any_on | output | 1 | 1 while any channel is connected |

## Verification
Call E the rising edge that captures a strobed request. The sequencer reacts at edge E+1. A connection from the open state, or a disconnection, is therefore visible after E+1. On a channel change, the old channel is still closed after E, the tree is open after E+1 through E+`BBM_CYCLES`, and the new channel is closed after E+1+`BBM_CYCLES`. The bench drives its inputs on falling edges. It samples on the falling edge that follows each of these rising edges, so every check falls in the exact cycle in which a result becomes due. For hold and transparency cases, it waits several cycles and then checks the settled channel.

// File: rtl/msc_pkg.sv
package msc_pkg;
    typedef enum logic [1:0] {
        ST_OFF = 2'd0,
        ST_ON  = 2'd1,
        ST_GAP = 2'd2
    } seq_state_t;
endpackage

// File: rtl/msc_input_latch.sv
module msc_input_latch #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe,
    input  logic [ADDR_W-1:0] addr,
    input  logic              en,
    input  logic              cs,
    input  logic              cs_n,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_addr
);
    // Follows the inputs while strobe is high, holds while it is low.
    always_ff @(posedge clk) begin
        if (rst) begin
            req_valid <= 1'b0;
            req_addr  <= '0;
        end else if (strobe) begin
            req_valid <= en & cs & ~cs_n;
            req_addr  <= addr;
        end
    end
endmodule

// File: rtl/msc_sequencer.sv
module msc_sequencer
    import msc_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int BBM_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              conn,
    output logic [ADDR_W-1:0] conn_addr
);
    localparam int CNT_W = (BBM_CYCLES < 2) ? 1 : $clog2(BBM_CYCLES);
    localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(BBM_CYCLES - 1);

    seq_state_t        state_q, state_d;
    logic [ADDR_W-1:0] cur_q, cur_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_OFF;
            cur_q   <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cur_q   <= cur_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cur_d   = cur_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_OFF: begin
                if (req_valid) begin
                    cur_d   = req_addr;
                    state_d = ST_ON;
                end
            end
            ST_ON: begin
                if (!req_valid) begin
                    state_d = ST_OFF;
                end else if (req_addr != cur_q) begin
                    state_d = ST_GAP;
                    cnt_d   = '0;
                end
            end
            ST_GAP: begin
                if (cnt_q == GAP_LAST) begin
                    if (req_valid) begin
                        cur_d   = req_addr;
                        state_d = ST_ON;
                    end else begin
                        state_d = ST_OFF;
                    end
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: state_d = ST_OFF;
        endcase
    end

    // Outputs
    always_comb begin
        conn      = (state_q == ST_ON);
        conn_addr = cur_q;
    end
endmodule

// File: rtl/msc_gate_drive.sv
module msc_gate_drive #(
    parameter int N_CH      = 16,
    parameter int BANK_SIZE = 8,
    parameter int ADDR_W    = 4,
    parameter int N_BANK    = 2
) (
    input  logic              conn,
    input  logic [ADDR_W-1:0] conn_addr,
    output logic [N_CH-1:0]   ch_ser_in,
    output logic [N_CH-1:0]   ch_ser_out,
    output logic [N_CH-1:0]   ch_shunt,
    output logic [N_BANK-1:0] bank_ser
);
    localparam int CELL_W = $clog2(BANK_SIZE);
    localparam int BANK_W = ADDR_W - CELL_W;

    logic [BANK_W-1:0] bank_idx;
    assign bank_idx = conn_addr[ADDR_W-1:CELL_W];

    for (genvar i = 0; i < N_CH; i++) begin : g_cell
        logic pick;
        assign pick          = conn && (conn_addr == ADDR_W'(i));
        assign ch_ser_in[i]  = pick;
        assign ch_ser_out[i] = pick;
        assign ch_shunt[i]   = ~pick;
    end

    for (genvar b = 0; b < N_BANK; b++) begin : g_bank
        assign bank_ser[b] = conn && (bank_idx == BANK_W'(b));
    end
endmodule

// File: rtl/mux_switch_ctrl.sv
module mux_switch_ctrl #(
    parameter int N_CH       = 16,
    parameter int BANK_SIZE  = 8,
    parameter int BBM_CYCLES = 2,
    localparam int ADDR_W    = $clog2(N_CH),
    localparam int N_BANK    = N_CH / BANK_SIZE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe,
    input  logic [ADDR_W-1:0] addr,
    input  logic              en,
    input  logic              cs,
    input  logic              cs_n,
    output logic [N_CH-1:0]   ch_ser_in,
    output logic [N_CH-1:0]   ch_ser_out,
    output logic [N_CH-1:0]   ch_shunt,
    output logic [N_BANK-1:0] bank_ser,
    output logic              any_on
);
    logic              req_valid;
    logic [ADDR_W-1:0] req_addr;
    logic              conn;
    logic [ADDR_W-1:0] conn_addr;

    msc_input_latch #(.ADDR_W(ADDR_W)) u_latch (
        .clk(clk), .rst(rst), .strobe(strobe), .addr(addr),
        .en(en), .cs(cs), .cs_n(cs_n),
        .req_valid(req_valid), .req_addr(req_addr)
    );

    msc_sequencer #(.ADDR_W(ADDR_W), .BBM_CYCLES(BBM_CYCLES)) u_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .conn(conn), .conn_addr(conn_addr)
    );

    msc_gate_drive #(
        .N_CH(N_CH), .BANK_SIZE(BANK_SIZE), .ADDR_W(ADDR_W), .N_BANK(N_BANK)
    ) u_drive (
        .conn(conn), .conn_addr(conn_addr),
        .ch_ser_in(ch_ser_in), .ch_ser_out(ch_ser_out),
        .ch_shunt(ch_shunt), .bank_ser(bank_ser)
    );

    assign any_on = conn;
endmodule

// File: rtl/msc_checker.sv
module msc_checker #(
    parameter int N_CH      = 16,
    parameter int BANK_SIZE = 8,
    parameter int N_BANK    = 2
) (
    input logic              clk,
    input logic              rst,
    input logic [N_CH-1:0]   ch_ser_in,
    input logic [N_CH-1:0]   ch_ser_out,
    input logic [N_CH-1:0]   ch_shunt,
    input logic [N_BANK-1:0] bank_ser,
    input logic              any_on
);
    a_r5_tcell_complement: assert property (@(posedge clk) disable iff (rst)
        (ch_ser_in == ch_ser_out) && (ch_shunt == ~ch_ser_in));

    a_r6_one_channel: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ch_ser_in));

    a_r6_one_bank: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bank_ser));

    a_r8_status_any: assert property (@(posedge clk) disable iff (rst)
        any_on == (|ch_ser_in));

    a_r9_break_first: assert property (@(posedge clk) disable iff (rst)
        ((|ch_ser_in) && (|$past(ch_ser_in))) |-> (ch_ser_in == $past(ch_ser_in)));

    a_r10_reset_open: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> ((ch_ser_in == '0) && (bank_ser == '0) && !any_on));

    for (genvar b = 0; b < N_BANK; b++) begin : g_bchk
        a_r7_bank_holds_channel: assert property (@(posedge clk) disable iff (rst)
            bank_ser[b] |-> (|ch_ser_in[b*BANK_SIZE +: BANK_SIZE]));
    end
endmodule

bind mux_switch_ctrl msc_checker #(
    .N_CH(N_CH), .BANK_SIZE(BANK_SIZE), .N_BANK(N_BANK)
) u_msc_checker (
    .clk(clk), .rst(rst), .ch_ser_in(ch_ser_in), .ch_ser_out(ch_ser_out),
    .ch_shunt(ch_shunt), .bank_ser(bank_ser), .any_on(any_on)
);

// File: tb/test_mux_switch_ctrl.sv
module test_mux_switch_ctrl;
    localparam int BBM = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        strobe = 1'b0;
    logic [3:0]  addr = 4'd0;
    logic        en = 1'b0, cs = 1'b0, cs_n = 1'b1;
    logic [15:0] ch_ser_in, ch_ser_out, ch_shunt;
    logic [1:0]  bank_ser;
    logic        any_on;

    int total = 0;
    int bad = 0;
    int mon_r6 = 0;
    int mon_r8 = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    mux_switch_ctrl #(.N_CH(16), .BANK_SIZE(8), .BBM_CYCLES(BBM)) i_mux_switch_ctrl (
        .clk(clk), .rst(rst), .strobe(strobe), .addr(addr), .en(en), .cs(cs),
        .cs_n(cs_n), .ch_ser_in(ch_ser_in), .ch_ser_out(ch_ser_out),
        .ch_shunt(ch_shunt), .bank_ser(bank_ser), .any_on(any_on)
    );

    // Continuous monitor for R6 and R8, sampled on falling edges
    always @(negedge clk) begin
        if (!rst) begin
            if (!$onehot0(ch_ser_in) || !$onehot0(bank_ser)) mon_r6++;
            if (any_on != (|ch_ser_in)) mon_r8++;
        end
    end

    task automatic chk(input string tag, input bit exp_on, input int ch);
        logic [15:0] e_ser;
        logic [1:0]  e_bank;
        e_ser  = exp_on ? (16'd1 << ch) : 16'd0;
        e_bank = exp_on ? (2'd1 << (ch / 8)) : 2'd0;
        total++;
        if (ch_ser_in !== e_ser || ch_ser_out !== e_ser || ch_shunt !== ~e_ser
            || bank_ser !== e_bank || any_on !== exp_on) begin
            bad++;
            $display("FAIL %s: ser_in=%h ser_out=%h shunt=%h bank=%b on=%b exp ser=%h shunt=%h bank=%b on=%b",
                     tag, ch_ser_in, ch_ser_out, ch_shunt, bank_ser, any_on,
                     e_ser, ~e_ser, e_bank, exp_on);
        end
    endtask

    // Drive a request with strobe high for one rising edge; returns at the next falling edge
    task automatic put(input int a, input bit e, input bit c, input bit cn);
        @(negedge clk);
        addr = 4'(a); en = e; cs = c; cs_n = cn; strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0;
    endtask

    task automatic go_off();
        put(0, 1'b0, 1'b0, 1'b1);
        repeat (BBM + 2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 reset state", 1'b0, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 after reset", 1'b0, 0);

        // R3 / R4 / R7: full address map, each from open state
        for (int k = 0; k < 16; k++) begin
            put(k, 1'b1, 1'b1, 1'b0);
            @(negedge clk);
            chk($sformatf("R3 R7 map code %0d", k), 1'b1, k);
            put(k, 1'b0, 1'b1, 1'b0);
            @(negedge clk);
            chk($sformatf("R4 drop code %0d", k), 1'b0, 0);
        end

        // R2: all qualifier combinations
        for (int q = 0; q < 8; q++) begin
            bit e, c, cn;
            e = q[2]; c = q[1]; cn = q[0];
            put(5, e, c, cn);
            @(negedge clk);
            chk($sformatf("R2 en=%0d cs=%0d cs_n=%0d", e, c, cn), e & c & ~cn, 5);
            go_off();
        end

        // R9: cross-bank change 3 -> 12
        put(3, 1'b1, 1'b1, 1'b0);
        @(negedge clk);
        chk("R9 start on 3", 1'b1, 3);
        put(12, 1'b1, 1'b1, 1'b0);
        chk("R9 old still closed", 1'b1, 3);
        for (int g = 0; g < BBM; g++) begin
            @(negedge clk);
            chk($sformatf("R9 gap cycle %0d", g), 1'b0, 0);
        end
        @(negedge clk);
        chk("R9 new closed 12", 1'b1, 12);

        // R9: same-bank change 12 -> 13
        put(13, 1'b1, 1'b1, 1'b0);
        for (int g = 0; g < BBM; g++) begin
            @(negedge clk);
            chk($sformatf("R9 same-bank gap %0d", g), 1'b0, 0);
        end
        @(negedge clk);
        chk("R9 new closed 13", 1'b1, 13);

        // R11: re-strobe the connected address
        put(13, 1'b1, 1'b1, 1'b0);
        for (int g = 0; g < BBM + 2; g++) begin
            @(negedge clk);
            chk($sformatf("R11 no gap cycle %0d", g), 1'b1, 13);
        end

        // R1: hold while strobe low
        @(negedge clk);
        addr = 4'd7; en = 1'b0; cs = 1'b0; cs_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1 hold with strobe low", 1'b1, 13);

        // R1: transparent over several edges, last value wins
        @(negedge clk);
        strobe = 1'b1; addr = 4'd1; en = 1'b1; cs = 1'b1; cs_n = 1'b0;
        @(negedge clk) addr = 4'd2;
        @(negedge clk) addr = 4'd9;
        @(negedge clk) strobe = 1'b0; addr = 4'd4;
        repeat (3 * (BBM + 2)) @(negedge clk);
        chk("R1 transparent settles on 9", 1'b1, 9);

        // R9: withdrawal during the gap ends open
        put(0, 1'b1, 1'b1, 1'b0);
        put(0, 1'b1, 1'b0, 1'b0);
        repeat (BBM + 2) @(negedge clk);
        chk("R9 withdraw in gap", 1'b0, 0);

        // R10: reset while connected, held select cleared
        put(6, 1'b1, 1'b1, 1'b0);
        @(negedge clk);
        chk("R10 pre-reset on 6", 1'b1, 6);
        rst = 1'b1;
        @(negedge clk);
        chk("R10 reset while on", 1'b0, 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        chk("R10 stays open after reset", 1'b0, 0);

        total++;
        if (mon_r6 != 0) begin
            bad++;
            $display("FAIL R6 monitor: violations=%0d expected=0", mon_r6);
        end
        total++;
        if (mon_r8 != 0) begin
            bad++;
            $display("FAIL R8 monitor: mismatches=%0d expected=0", mon_r8);
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule